// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block produces a slow core-clock enable from a fast reference clock. The divide ratio may be fractional. It uses two integer divisors. It spends a programmable number of output periods at the first divisor and then a programmable number at the second, and repeats. Over one full sequence the average output period is (M1·N1 + M2·N2)/(M1+M2) reference cycles. With divisors 733 and 732 and counts 8 and 11, a 24 MHz reference gives about 32.768 kHz.

The configuration arrives as two 32-bit control words. Control word A carries both divisors, the dual-mode enable and the two gates. Control word B carries both repeat counts and a bypass. The result comes out in two forms: a one-cycle enable pulse, and a clock that toggles on every pulse. A status output shows whether either gate is set. Software clears the input gate, changes the settings, and then sets the gate again. The block copies the settings only while the input gate is clear.

Top module: `frac_clkdiv`

## Requirements
- R1: After reset, `tick_o` and `clk_o` are low, and counting starts in the first-divider phase once the input gate is set.
- R2: Single mode (word A bit 28 clear). With the input gate (word A bit 31) set, a tick is produced every N1 cycles, where N1 is word A bits [11:0] plus one. The first tick is registered on the N1-th clock edge that samples the gate high.
- R3: Dual mode (word A bit 28 set). The block produces M1 ticks spaced N1 cycles apart, then M2 ticks spaced N2 cycles apart, and repeats. N2 is word A bits [23:12] plus one. M1 and M2 are word B bits [11:0] and [23:12], each plus one.
- R4: Bypass (word B bit 24 set). While the input gate is set, a tick is produced on every reference cycle.
- R5: The divisors, repeat counts, dual enable and bypass are copied only on edges where the input gate is clear. Changes made while it is set have no effect.
- R6: While the input gate is clear, no ticks are produced, `clk_o` is low, and the sequence restarts from the first-divider phase.
- R7: While the output gate (word A bit 30) is clear, `tick_o` and `clk_o` are low. The internal sequence keeps its timing.
- R8: `clk_o` inverts on every tick and starts low when the input gate is set.
- R9: `enabled_o` is high exactly when word A bit 31 or bit 30 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_a_i | input | 32 | Divisors, dual enable, input and output gates |
| ctl_b_i | input | 32 | Repeat counts and bypass |
| tick_o | output | 1 | One-cycle output enable pulse |
| clk_o | output | 1 | Toggled divided clock |
| enabled_o | output | 1 | High when either gate is set |

## Verification
A wrong divisor or repeat counter moves a tick by at least one reference cycle. This shows up at the pulse output within one output period. A phase bit that flips at the wrong time changes the tick spacing within one sequence of M1+M2 ticks. The bench compares both outputs on every cycle against a countdown model. It also counts the ticks of the full sequence for the typical setting, so a slip of a single cycle anywhere in the sequence is caught. Settings that are copied while the block is running show up as wrong spacing immediately after the change.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    parameter int DIV_W = 12;

    localparam int A_N1_LSB = 0;
    localparam int A_N2_LSB = DIV_W;
    localparam int A_DUAL   = 28;
    localparam int A_OUTEN  = 30;
    localparam int A_INEN   = 31;
    localparam int B_M1_LSB = 0;
    localparam int B_M2_LSB = DIV_W;
    localparam int B_BYPASS = 24;

    typedef struct packed {
        logic [DIV_W-1:0] n1;
        logic [DIV_W-1:0] n2;
        logic [DIV_W-1:0] m1;
        logic [DIV_W-1:0] m2;
        logic             dual;
        logic             bypass;
    } cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] rep;
        logic             phase;
    } ctr_t;

    typedef struct packed {
        logic tick;
        logic tog;
    } out_t;
endpackage

// File: rtl/fdiv_cfg_latch.sv
module fdiv_cfg_latch
    import fdiv_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        run_i,
    input  logic [31:0] ctl_a_i,
    input  logic [31:0] ctl_b_i,
    output cfg_t        cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!run_i) begin
            cfg_d.n1     = ctl_a_i[A_N1_LSB +: DIV_W];
            cfg_d.n2     = ctl_a_i[A_N2_LSB +: DIV_W];
            cfg_d.m1     = ctl_b_i[B_M1_LSB +: DIV_W];
            cfg_d.m2     = ctl_b_i[B_M2_LSB +: DIV_W];
            cfg_d.dual   = ctl_a_i[A_DUAL];
            cfg_d.bypass = ctl_b_i[B_BYPASS];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |=> $stable(cfg_q)); // R5
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter
    import fdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  cfg_t cfg_i,
    output logic wrap_o
);
    ctr_t ctr_d, ctr_q;
    logic [DIV_W-1:0] div_lim, rep_lim;
    logic wrap;

    always_comb begin
        ctr_d   = ctr_q;
        wrap    = 1'b0;
        div_lim = ctr_q.phase ? cfg_i.n2 : cfg_i.n1;
        rep_lim = ctr_q.phase ? cfg_i.m2 : cfg_i.m1;
        if (!run_i) begin
            ctr_d = '0;
        end else if (!cfg_i.bypass) begin
            if (ctr_q.cnt == div_lim) begin
                ctr_d.cnt = '0;
                wrap      = 1'b1;
                if (ctr_q.rep == rep_lim) begin
                    ctr_d.rep   = '0;
                    ctr_d.phase = cfg_i.dual ? ~ctr_q.phase : 1'b0;
                end else begin
                    ctr_d.rep = ctr_q.rep + 1'b1;
                end
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctr_q <= '0;
        else         ctr_q <= ctr_d;
    end

    assign wrap_o = wrap;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctr_q.cnt <= div_lim && ctr_q.rep <= rep_lim); // R3
    AST_SINGLE_STAYS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_i.dual |-> !ctr_q.phase); // R2
    AST_IDLE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (ctr_q == '0)); // R6
endmodule

// File: rtl/fdiv_outstage.sv
module fdiv_outstage
    import fdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic pulse_i,
    input  logic oen_i,
    output logic tick_raw_o,
    output logic tick_o,
    output logic clk_o
);
    out_t out_d, out_q;

    always_comb begin
        out_d.tick = run_i & pulse_i;
        out_d.tog  = run_i ? (out_q.tog ^ pulse_i) : 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tick_raw_o = out_q.tick;
    assign tick_o     = out_q.tick & oen_i;
    assign clk_o      = out_q.tog & oen_i;

    AST_TOGGLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && $past(run_i) && (out_q.tog != $past(out_q.tog)) |-> out_q.tick); // R8
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !out_q.tick && !out_q.tog); // R6
endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv
    import fdiv_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] ctl_a_i,
    input  logic [31:0] ctl_b_i,
    output logic        tick_o,
    output logic        clk_o,
    output logic        enabled_o
);
    logic run, oen, wrap, pulse, tick_raw;
    cfg_t cfg;

    assign run       = ctl_a_i[A_INEN];
    assign oen       = ctl_a_i[A_OUTEN];
    assign enabled_o = run | oen;

    fdiv_cfg_latch u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .ctl_a_i(ctl_a_i),
        .ctl_b_i(ctl_b_i),
        .cfg_o  (cfg)
    );

    fdiv_counter u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .cfg_i  (cfg),
        .wrap_o (wrap)
    );

    assign pulse = cfg.bypass | wrap;

    fdiv_outstage u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .pulse_i   (pulse),
        .oen_i     (oen),
        .tick_raw_o(tick_raw),
        .tick_o    (tick_o),
        .clk_o     (clk_o)
    );

    AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run && cfg.bypass |=> tick_raw); // R4
endmodule

// File: tb/frac_clkdiv_test.sv
module frac_clkdiv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctl_a = '0;
    logic [31:0] ctl_b = '0;
    logic        tick_o, clk_o, enabled_o;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    frac_clkdiv uut (
        .clk_i(clk), .rst_ni(rst_n), .ctl_a_i(ctl_a), .ctl_b_i(ctl_b),
        .tick_o(tick_o), .clk_o(clk_o), .enabled_o(enabled_o)
    );

    // behavioural reference: countdown to the next tick
    logic [31:0] sh_a = '0, sh_b = '0;
    int  left, reps, ph;
    bit  started = 0, m_tick = 0, m_tog = 0;

    function automatic int fld(input logic [31:0] w, input int lsb);
        return int'(w[lsb +: 12]) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            sh_a = '0; sh_b = '0; started = 0; m_tick = 0; m_tog = 0;
        end else if (!ctl_a[31]) begin
            sh_a = ctl_a; sh_b = ctl_b; started = 0; m_tick = 0; m_tog = 0;
        end else if (sh_b[24]) begin
            m_tick = 1; m_tog = ~m_tog;
        end else begin
            if (!started) begin
                left = fld(sh_a, 0); reps = fld(sh_b, 0); ph = 0; started = 1;
            end
            left--;
            m_tick = 0;
            if (left == 0) begin
                m_tick = 1;
                reps--;
                if (reps == 0) begin
                    if (sh_a[28]) ph = 1 - ph;
                    reps = (ph == 1) ? fld(sh_b, 12) : fld(sh_b, 0);
                end
                left = (ph == 1) ? fld(sh_a, 12) : fld(sh_a, 0);
            end
            if (m_tick) m_tog = ~m_tog;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("tick_o", tick_o, m_tick & ctl_a[30]);
            check("clk_o", clk_o, m_tog & ctl_a[30]);
            check("enabled_o", enabled_o, ctl_a[31] | ctl_a[30]);
        end
    end

    task automatic drive(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk); #1;
        ctl_a = a; ctl_b = b;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] word_a(input int n1, input int n2, input bit dual,
                                           input bit ien, input bit oen);
        logic [31:0] w = '0;
        w[11:0] = 12'(n1 - 1); w[23:12] = 12'(n2 - 1);
        w[28] = dual; w[30] = oen; w[31] = ien;
        return w;
    endfunction

    function automatic logic [31:0] word_b(input int m1, input int m2, input bit byp);
        logic [31:0] w = '0;
        w[11:0] = 12'(m1 - 1); w[23:12] = 12'(m2 - 1); w[24] = byp;
        return w;
    endfunction

    initial begin
        #(150000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt;
        wait_cyc(3);
        cur_req = "R1";
        check("reset tick_o", tick_o, 0);
        check("reset clk_o", clk_o, 0);
        drive('0, '0);
        rst_n = 1'b1;
        wait_cyc(3);

        // R2 single mode, divisor 5; R1 starts in first phase
        cur_req = "R2";
        drive(word_a(5, 3, 0, 0, 1), word_b(2, 2, 0));
        drive(word_a(5, 3, 0, 1, 1), word_b(2, 2, 0));
        wait_cyc(40);

        // R3 dual mode, small values
        cur_req = "R6";
        drive(word_a(4, 3, 1, 0, 1), word_b(2, 3, 0));
        wait_cyc(3);
        cur_req = "R3";
        drive(word_a(4, 3, 1, 1, 1), word_b(2, 3, 0));
        wait_cyc(80);

        // R5 changes while running are ignored
        cur_req = "R5";
        drive(word_a(9, 7, 0, 1, 1), word_b(1, 1, 1));
        wait_cyc(40);

        // R7 output gate clear while running
        cur_req = "R7";
        drive(word_a(9, 7, 0, 1, 0), word_b(1, 1, 1));
        wait_cyc(20);
        drive(word_a(9, 7, 0, 1, 1), word_b(1, 1, 1));
        wait_cyc(20);

        // R4 bypass
        cur_req = "R4";
        drive(word_a(9, 7, 0, 0, 1), word_b(1, 1, 1));
        drive(word_a(9, 7, 0, 1, 1), word_b(1, 1, 1));
        wait_cyc(10);

        // R8 toggled clock, divisor 1 and 2
        cur_req = "R8";
        drive(word_a(1, 2, 1, 0, 1), word_b(3, 2, 0));
        drive(word_a(1, 2, 1, 1, 1), word_b(3, 2, 0));
        wait_cyc(30);

        // R9 status combinations
        cur_req = "R9";
        drive(word_a(2, 2, 0, 0, 0), '0);
        wait_cyc(2);
        check("enabled none", enabled_o, 0);
        drive(word_a(2, 2, 0, 0, 1), '0);
        wait_cyc(2);
        check("enabled out", enabled_o, 1);
        drive(word_a(2, 2, 0, 1, 0), '0);
        wait_cyc(2);
        check("enabled in", enabled_o, 1);

        // R3 typical setting: 19 ticks in 8*733+11*732 cycles
        cur_req = "R3";
        drive(word_a(733, 732, 1, 0, 1), word_b(8, 11, 0));
        drive(word_a(733, 732, 1, 1, 1), word_b(8, 11, 0));
        cnt = 0;
        for (int i = 0; i < 13916; i++) begin
            @(negedge clk);
            if (tick_o) cnt++;
        end
        check("ticks per sequence", cnt, 19);
        wait_cyc(2000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule